// File: doc/BRIEF.md
# FM Operator Modulation Router

This block sits after the operator output stage of a time-multiplexed FM voice engine. Every clock cycle one operator word of one voice arrives. The router turns that word, together with the per-voice state it holds, into the modulation word for the next operator of the same voice. In the same cycle it keeps building the voice's output sum. The voices are served in strict rotation. A voice's state therefore lives in rotating delay lines whose length equals the voice count, and each stored value comes back at the tap in the same cycle that the voice returns.

The control for each slot comes from an external sequencer. A 3-bit source code picks one of five modulation sources. One bit moves the incoming word into a two-deep feedback history. Two bits set the operation on the shared memory/sum register. A feedback-level input scales the averaged self-feedback path. A load strobe copies the finished sum into an output buffer. Phase generation, sine lookup and envelope scaling take place elsewhere.

Top module: `fm_mod_router`

## Requirements
- R1: While reset is low, and until the first clock edge after reset is released, `mod_word` and `out_word` are zero. Every stored memory and feedback entry is zero, so each stored operand read during the first rotation after reset is zero.
- R2: A value written into per-voice storage in cycle t is the stored operand in cycle t+NV (NV=16), and in no earlier cycle.
- R3: `mod_word` is registered and reflects the inputs present at the previous rising edge. Source codes 0, 6 and 7 produce zero.
- R4: Source code 1 produces the incoming operator word unchanged.
- R5: Source code 2 produces the stored memory value plus the incoming word. The sum saturates to the range [-8192, 8191] of the 14-bit two's complement format.
- R6: Source code 3 produces the stored memory value. Source code 4 produces the newest stored feedback value.
- R7: Source code 5 produces floor((newest + older feedback)/2), then shifted arithmetically right by (8 − level) for levels 1 to 7. A level of 0 gives zero.
- R8: The memory operation is selected by {mem_c, mem_d}. 2'b10 keeps the stored value. 2'b01 stores the incoming word. 2'b11 stores the saturated sum of the stored value and the incoming word. 2'b00 stores zero.
- R9: With `fb_push` high, the incoming word becomes the newest feedback entry and the previous newest becomes the older entry. With `fb_push` low, both entries are kept.
- R10: With `out_load` high, `out_word` takes, at the next rising edge, the value being written into the memory register in that cycle. Otherwise `out_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one operator slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_word | input | 14 | Signed output of the current operator |
| mod_sel | input | 3 | Modulation source code |
| fb_push | input | 1 | Push the operator word into the feedback history |
| mem_c | input | 1 | Memory operation bit, upper |
| mem_d | input | 1 | Memory operation bit, lower |
| fb_level | input | 3 | Self-feedback level, 0 turns the path off |
| out_load | input | 1 | Copy the memory value being written into the output buffer |
| mod_word | output | 14 | Registered modulation word for the next operator |
| out_word | output | 14 | Output buffer holding the voice sum |

## Verification
The embedded properties check on every cycle the behaviour that depends only on the previous cycle. This covers the direct and zero sources, the stored-memory source, the feedback-off case, the absence of sign wrap in the summed source, and the hold of the output buffer. Behaviour that spans a full rotation cannot be checked by those properties. This includes the return of a value exactly sixteen cycles later, the four memory operations, the feedback history shift and the averaged feedback scaling. Only the bench's queue model shows these, by comparing both outputs every cycle during algorithm-like slot sequences, random control and extreme operand values.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
   typedef enum logic [2:0] {
      SRC_NONE   = 3'd0,
      SRC_DIRECT = 3'd1,
      SRC_SUM    = 3'd2,
      SRC_MEM    = 3'd3,
      SRC_FB_ONE = 3'd4,
      SRC_FB_AVG = 3'd5
   } mod_src_e;

   typedef enum logic [1:0] {
      MEM_CLEAR = 2'b00,
      MEM_LOAD  = 2'b01,
      MEM_HOLD  = 2'b10,
      MEM_ACC   = 2'b11
   } mem_op_e;
endpackage

// File: rtl/fmr_delay_line.sv
module fmr_delay_line #(
   parameter int W     = 14,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] tap
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fmr_delay_line: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else begin
         stage[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign tap = stage[DEPTH-1];
endmodule

// File: rtl/fmr_sat_add.sv
module fmr_sat_add #(
   parameter int W = 14
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y
);
   localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic signed [W:0] wide;
   logic              ovf;

   assign wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
   assign ovf  = wide[W] ^ wide[W-1];

   always_comb begin
      if (ovf) y = wide[W] ? MINV : MAXV;
      else     y = wide[W-1:0];
   end
endmodule

// File: rtl/fmr_mod_select.sv
module fmr_mod_select
   import fmr_pkg::*;
#(
   parameter int DW  = 14,
   parameter int FBW = 3
) (
   input  logic [2:0]           sel,
   input  logic signed [DW-1:0] x,
   input  logic signed [DW-1:0] mem,
   input  logic signed [DW-1:0] sum,
   input  logic signed [DW-1:0] fb_new,
   input  logic signed [DW-1:0] fb_old,
   input  logic [FBW-1:0]       level,
   output logic signed [DW-1:0] mod
);
   localparam int FB_TOP = 1 << FBW;
   localparam int SHW    = $clog2(FB_TOP + 2);

   logic signed [DW:0]    fb_sum;
   logic [SHW-1:0]        shamt;
   logic signed [DW-1:0]  fb_avg;

   assign fb_sum = $signed({fb_new[DW-1], fb_new}) + $signed({fb_old[DW-1], fb_old});
   // one extra place for the halving of the two-entry average
   assign shamt  = SHW'(FB_TOP + 1) - SHW'(level);

   generate
      if (FBW < 1 || FB_TOP + 1 > DW + 1) begin : g_bad_fbw
         $error("fmr_mod_select: FBW out of range for DW");
      end
   endgenerate

   always_comb begin
      if (level == '0) fb_avg = '0;
      else             fb_avg = DW'(fb_sum >>> shamt);
   end

   always_comb begin
      case (mod_src_e'(sel))
         SRC_DIRECT: mod = x;
         SRC_SUM:    mod = sum;
         SRC_MEM:    mod = mem;
         SRC_FB_ONE: mod = fb_new;
         SRC_FB_AVG: mod = fb_avg;
         default:    mod = '0;
      endcase
   end
endmodule

// File: rtl/fm_mod_router.sv
module fm_mod_router
   import fmr_pkg::*;
#(
   parameter int DW  = 14,
   parameter int NV  = 16,
   parameter int FBW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] op_word,
   input  logic [2:0]           mod_sel,
   input  logic                 fb_push,
   input  logic                 mem_c,
   input  logic                 mem_d,
   input  logic [FBW-1:0]       fb_level,
   input  logic                 out_load,
   output logic signed [DW-1:0] mod_word,
   output logic signed [DW-1:0] out_word
);
   generate
      if (DW < 4)  begin : g_bad_dw  $error("fm_mod_router: DW must be at least 4");  end
      if (NV < 2)  begin : g_bad_nv  $error("fm_mod_router: NV must be at least 2");  end
   endgenerate

   logic signed [DW-1:0] mem_tap, fb_new_tap, fb_old_tap;
   logic signed [DW-1:0] mem_next, fb_new_next, fb_old_next;
   logic signed [DW-1:0] acc_sum, mod_next;
   mem_op_e              mem_op;

   fmr_delay_line #(.W(DW), .DEPTH(NV)) u_mem_line (
      .clk(clk), .rst_n(rst_n), .din(mem_next), .tap(mem_tap));
   fmr_delay_line #(.W(DW), .DEPTH(NV)) u_fb_new_line (
      .clk(clk), .rst_n(rst_n), .din(fb_new_next), .tap(fb_new_tap));
   fmr_delay_line #(.W(DW), .DEPTH(NV)) u_fb_old_line (
      .clk(clk), .rst_n(rst_n), .din(fb_old_next), .tap(fb_old_tap));

   fmr_sat_add #(.W(DW)) u_acc_add (.a(mem_tap), .b(op_word), .y(acc_sum));

   fmr_mod_select #(.DW(DW), .FBW(FBW)) u_sel (
      .sel(mod_sel), .x(op_word), .mem(mem_tap), .sum(acc_sum),
      .fb_new(fb_new_tap), .fb_old(fb_old_tap), .level(fb_level), .mod(mod_next));

   assign mem_op = mem_op_e'({mem_c, mem_d});

   always_comb begin
      case (mem_op)
         MEM_LOAD: mem_next = op_word;
         MEM_HOLD: mem_next = mem_tap;
         MEM_ACC:  mem_next = acc_sum;
         default:  mem_next = '0;
      endcase
   end

   assign fb_new_next = fb_push ? op_word    : fb_new_tap;
   assign fb_old_next = fb_push ? fb_new_tap : fb_old_tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_word <= '0;
         out_word <= '0;
      end else begin
         mod_word <= mod_next;
         if (out_load) out_word <= mem_next;
      end
   end

   // R4
   direct_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_sel == 3'd1 |=> mod_word == $past(op_word));
   // R3
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_sel == 3'd0 || mod_sel > 3'd5) |=> mod_word == '0);
   // R7
   fb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_sel == 3'd5 && fb_level == '0) |=> mod_word == '0);
   // R6
   mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_sel == 3'd3 |=> mod_word == $past(mem_tap));
   // R5
   sum_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_sel == 3'd2 && op_word[DW-1] == mem_tap[DW-1]) |=> mod_word[DW-1] == $past(op_word[DW-1]));
   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_load |=> $stable(out_word));
endmodule

// File: tb/fm_mod_router_tb.sv
module fm_mod_router_tb;
   localparam int NV = 16;
   localparam int MAXV = 8191;
   localparam int MINV = -8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [13:0] op_word = '0;
   logic [2:0] mod_sel = '0;
   logic fb_push = 1'b0, mem_c = 1'b0, mem_d = 1'b0, out_load = 1'b0;
   logic [2:0] fb_level = '0;
   logic signed [13:0] mod_word, out_word;

   int checks = 0;
   int errors = 0;
   int qm[$], qf0[$], qf1[$];
   int exp_mod = 0, exp_out = 0;

   always #5 clk = ~clk;

   fm_mod_router u_dut (
      .clk(clk), .rst_n(rst_n), .op_word(op_word), .mod_sel(mod_sel),
      .fb_push(fb_push), .mem_c(mem_c), .mem_d(mem_d), .fb_level(fb_level),
      .out_load(out_load), .mod_word(mod_word), .out_word(out_word));

   function automatic int sat(input int v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic string tag_of(input int s);
      case (s)
         1: return "R4";
         2: return "R5/R8/R2";
         3: return "R6/R8/R2";
         4: return "R6/R9/R2";
         5: return "R7/R9/R2";
         default: return "R3";
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one slot at a falling edge, update the model, check at the next falling edge
   task automatic step(input int s, input int a, input int c, input int d,
                       input int lvl, input int ol, input int x);
      int m, f0, f1, mv, mn, sumv;
      op_word = 14'(x); mod_sel = 3'(s); fb_push = a[0]; mem_c = c[0]; mem_d = d[0];
      fb_level = 3'(lvl); out_load = ol[0];
      m = qm.pop_front(); f0 = qf0.pop_front(); f1 = qf1.pop_front();
      sumv = sat(m + x);
      case (s)
         1: mv = x;
         2: mv = sumv;
         3: mv = m;
         4: mv = f0;
         5: mv = (lvl == 0) ? 0 : (((f0 + f1) >>> 1) >>> (8 - lvl));
         default: mv = 0;
      endcase
      case ({c[0], d[0]})
         2'b01: mn = x;
         2'b10: mn = m;
         2'b11: mn = sumv;
         default: mn = 0;
      endcase
      qm.push_back(mn);
      if (a != 0) begin qf0.push_back(x); qf1.push_back(f0); end
      else        begin qf0.push_back(f0); qf1.push_back(f1); end
      if (ol != 0) exp_out = mn;
      exp_mod = mv;
      @(negedge clk);
      check(tag_of(s), int'(mod_word), exp_mod);
      check("R10", int'(out_word), exp_out);
   endtask

   function automatic int rnd_word();
      case ($urandom_range(0, 5))
         0: return MAXV;
         1: return MINV;
         2: return $urandom_range(0, 15) - 8;
         default: return int'($urandom_range(0, 16383)) - 8192;
      endcase
   endfunction

   // small slot programs in the style of FM algorithms: {sel, a, c, d, ol}
   function automatic int prog_row(input int alg, input int slot);
      if (alg == 0) begin
         case (slot)
            0: return 'h1_1_0_0_0; 1: return 'h5_0_0_1_0; 2: return 'h2_1_1_1_0;
            3: return 'h0_0_0_1_0; 4: return 'h1_0_1_0_0; default: return 'h0_0_1_1_1;
         endcase
      end else begin
         case (slot)
            0: return 'h5_1_0_1_0; 1: return 'h4_0_0_1_0; 2: return 'h3_0_1_1_0;
            3: return 'h2_1_1_0_0; 4: return 'h5_0_1_1_0; default: return 'h0_0_1_1_1;
         endcase
      end
   endfunction

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NV; i++) begin qm.push_back(0); qf0.push_back(0); qf1.push_back(0); end
      repeat (3) @(negedge clk);
      // R1: outputs zero during reset
      check("R1", int'(mod_word), 0);
      check("R1", int'(out_word), 0);
      rst_n = 1'b1;
      check("R1", int'(mod_word), 0);
      // R1: first rotation reads zeros from storage
      for (int v = 0; v < NV; v++) step(3, 0, 1, 0, 0, 1, 100 + v);
      for (int v = 0; v < NV; v++) step(4, 0, 1, 0, 0, 0, 7);
      // R2: load per-voice marks, read them back exactly one rotation later
      for (int v = 0; v < NV; v++) step(1, 1, 0, 1, 0, 0, 1000 + 37 * v);
      for (int v = 0; v < NV; v++) step(3, 0, 1, 0, 0, 0, 0);
      for (int v = 0; v < NV; v++) step(4, 0, 1, 0, 0, 0, 0);
      // R8: clear then accumulate toward saturation
      for (int v = 0; v < NV; v++) step(0, 0, 0, 0, 0, 0, 5);
      for (int r = 0; r < 4; r++)
         for (int v = 0; v < NV; v++) step(2, 0, 1, 1, 0, 1, (v % 2 == 0) ? 3000 : -3000);
      // R7: level sweep over fixed feedback history
      for (int v = 0; v < NV; v++) step(0, 1, 1, 0, 0, 0, -5000 + 611 * v);
      for (int v = 0; v < NV; v++) step(0, 1, 1, 0, 0, 0, 4000 - 523 * v);
      for (int l = 0; l < 8; l++)
         for (int v = 0; v < NV; v++) step(5, 0, 1, 0, l, 0, 0);
      // algorithm-like slot programs
      for (int alg = 0; alg < 2; alg++)
         for (int rep = 0; rep < 8; rep++)
            for (int slot = 0; slot < 6; slot++)
               for (int v = 0; v < NV; v++) begin
                  int row;
                  row = prog_row(alg, slot);
                  step((row >> 16) & 7, (row >> 12) & 1, (row >> 8) & 1, (row >> 4) & 1,
                       1 + (rep % 7), row & 1, rnd_word());
               end
      // random control and extreme words
      for (int k = 0; k < 4000; k++)
         step($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1), rnd_word());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule